// File: doc/BRIEF.md
# Privileged Interrupt Priority Selector

This block decides which pending interrupt a hart with hypervisor support should take in the current cycle, and with which cause value. It looks at the pending vector against three privilege tiers in a fixed sequence: first machine, then hypervisor-supervisor, then virtual-supervisor. Each tier has its own global-enable rule, and each takes its candidates from the delegation masks. A later tier is considered only when every earlier tier produced no candidate bit at all.

Within the tier that wins, a fixed priority picks a single interrupt. Any enabled bit above position 11 is a platform-specific interrupt and outranks every standard one. Among the standard interrupts, the order does not follow the bit numbers. The choice is registered, so the take strobe and the cause appear one clock after the inputs are sampled. The trap entry itself and the logic that produces the pending bits belong to other blocks.

Top module: `irq_arbiter`

## Requirements
- R1: While reset (`rst_n` low) is sampled at a clock edge, `take_o` becomes 0 and `cause_o` becomes 0.
- R2: `take_o` and `cause_o` reflect the inputs sampled at the previous rising clock edge. A change in the inputs does not show at the outputs before the next edge.
- R3: Privilege is encoded U=0, S=1, M=3. Machine-tier candidates are the pending bits clear in `mdeleg_i`. This tier is enabled when privilege is below M, or when privilege is M and `mie_i` is 1.
- R4: Supervisor-tier candidates are considered only when the machine tier has no candidate. They are the pending bits set in `mdeleg_i` and clear in `hdeleg_i`. This tier is enabled when `virt_i` is 1, or privilege is U, or privilege is S and `sie_i` is 1. A machine-tier candidate wins even over a supervisor interrupt of higher standard rank.
- R5: Virtual-supervisor candidates are considered only when `virt_i` is 1 and the two earlier tiers have no candidate. They are the pending bits set in `hdeleg_i`. This tier is enabled when privilege is U, or when privilege is S and `sie_i` is 1.
- R6: While `dbg_i` is 1, no interrupt is taken.
- R7: If any candidate bit at position 12 or above exists, the lowest-numbered such bit is chosen, ahead of every standard interrupt.
- R8: Otherwise the standard bits are ranked 11 (machine external), 3 (machine software), 7 (machine timer), 9 (supervisor external), 1 (supervisor software), 5 (supervisor timer), 10 (virtual-supervisor external), 2 (virtual-supervisor software), 6 (virtual-supervisor timer). The first one present is chosen.
- R9: Bits 0, 4 and 8 are never chosen. If they are the only candidates, no interrupt is taken.
- R10: When `take_o` is 1, `cause_o` has its most significant bit set and the chosen bit index in its low $clog2(XLEN) bits, with all other bits zero. When `take_o` is 0, `cause_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pend_i | input | XLEN | Pending interrupt bits |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| virt_i | input | 1 | Hart runs virtualized |
| dbg_i | input | 1 | Hart is in debug mode |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| mdeleg_i | input | XLEN | Machine-to-supervisor delegation mask |
| hdeleg_i | input | XLEN | Supervisor-to-virtual-supervisor delegation mask |
| take_o | output | 1 | Take an interrupt (registered) |
| cause_o | output | XLEN | Interrupt cause value (registered) |

## Verification
The assertions check the following on every cycle:
- debug mode always suppresses the strobe;
- the cause is well formed, or zero when idle;
- a taken index was pending on the previous edge;
- bits 0, 4 and 8 are never reported;
- a machine hart with interrupts disabled and nothing delegated never takes an interrupt.

The assertions cannot show the tier sequencing, the enable rule of each tier, or the exact standard ranking. The table scenarios cover these, along with the lowest-wins rule for platform bits, a platform bit at the top position, and the one-cycle latency.

// File: rtl/irq_sel_pkg.sv
// Package: shared constants for the interrupt selector.
// Holds the privilege codes, the first platform-specific bit position
// and the standard priority ranking (highest first).
package irq_sel_pkg;
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    // First bit above the machine external interrupt
    localparam int unsigned CUSTOM_BASE = 12;

    // Standard ranking, highest priority first
    localparam int unsigned STD_COUNT = 9;
    localparam int unsigned STD_RANK [STD_COUNT] = '{11, 3, 7, 9, 1, 5, 10, 2, 6};
endpackage

// File: rtl/irq_tier_gate.sv
// Module: irq_tier_gate
// Applies the three privilege tiers in sequence and returns the candidate
// bits of the first tier that has any. Purely combinational.
// Assumes priv_i uses U=0, S=1, M=3. Code 2 is treated as below M and above S.
module irq_tier_gate
    import irq_sel_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] pend_i,
    input  logic [1:0]      priv_i,
    input  logic            virt_i,
    input  logic            mie_i,
    input  logic            sie_i,
    input  logic [XLEN-1:0] mdeleg_i,
    input  logic [XLEN-1:0] hdeleg_i,
    output logic [XLEN-1:0] cand_o
);
    logic            m_en, hs_en, vs_en;
    logic [XLEN-1:0] m_cand, hs_cand, vs_cand;

    // Global-enable rule for each tier
    always_comb begin
        m_en  = (priv_i != PRIV_M) || mie_i;
        vs_en = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && sie_i);
        hs_en = virt_i || vs_en;
    end

    // Candidate sets per tier
    always_comb begin
        m_cand  = pend_i & ~mdeleg_i & {XLEN{m_en}};
        hs_cand = pend_i & mdeleg_i & ~hdeleg_i & {XLEN{hs_en}};
        vs_cand = pend_i & hdeleg_i & {XLEN{vs_en && virt_i}};
    end

    // Take the first tier that has any candidate
    always_comb begin
        if (|m_cand)       cand_o = m_cand;
        else if (|hs_cand) cand_o = hs_cand;
        else               cand_o = vs_cand;
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Module: irq_prio_pick
// Picks one bit index from a candidate vector. Platform bits (CUSTOM_BASE
// and up) win, lowest first. After them comes the fixed standard ranking.
// Bits outside both sets are ignored. Purely combinational.
module irq_prio_pick
    import irq_sel_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int IW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] cand_i,
    output logic            found_o,
    output logic [IW-1:0]   idx_o
);
    logic          cust_hit, std_hit;
    logic [IW-1:0] cust_idx, std_idx;

    // Lowest platform bit: scan downwards so the last match is the lowest
    always_comb begin
        cust_hit = 1'b0;
        cust_idx = '0;
        for (int i = XLEN - 1; i >= int'(CUSTOM_BASE); i--) begin
            if (cand_i[i]) begin
                cust_hit = 1'b1;
                cust_idx = IW'(i);
            end
        end
    end

    // Standard ranking: scan from the lowest rank so the highest rank wins
    always_comb begin
        std_hit = 1'b0;
        std_idx = '0;
        for (int r = int'(STD_COUNT) - 1; r >= 0; r--) begin
            if (cand_i[STD_RANK[r]]) begin
                std_hit = 1'b1;
                std_idx = IW'(STD_RANK[r]);
            end
        end
    end

    // Merge the two classes: platform bits first
    always_comb begin
        found_o = cust_hit || std_hit;
        idx_o   = cust_hit ? cust_idx : std_idx;
    end
endmodule

// File: rtl/irq_arbiter.sv
// Module: irq_arbiter (top)
// Selects the interrupt to take from pending bits, privilege state and
// delegation masks, and registers the take strobe and cause value.
// Assumes XLEN is 32 or 64. Reset is synchronous and active low.
module irq_arbiter
    import irq_sel_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int IW  = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pend_i,
    input  logic [1:0]      priv_i,
    input  logic            virt_i,
    input  logic            dbg_i,
    input  logic            mie_i,
    input  logic            sie_i,
    input  logic [XLEN-1:0] mdeleg_i,
    input  logic [XLEN-1:0] hdeleg_i,
    output logic            take_o,
    output logic [XLEN-1:0] cause_o
);
    logic [XLEN-1:0] cand;
    logic            found;
    logic [IW-1:0]   idx;
    logic            take_d;
    logic [XLEN-1:0] cause_d;

    irq_tier_gate #(.XLEN(XLEN)) i_gate (
        .pend_i   (pend_i),
        .priv_i   (priv_i),
        .virt_i   (virt_i),
        .mie_i    (mie_i),
        .sie_i    (sie_i),
        .mdeleg_i (mdeleg_i),
        .hdeleg_i (hdeleg_i),
        .cand_o   (cand)
    );

    irq_prio_pick #(.XLEN(XLEN)) i_pick (
        .cand_i  (cand),
        .found_o (found),
        .idx_o   (idx)
    );

    // Debug mode blocks the take; build the cause word from the index
    always_comb begin
        take_d  = found && !dbg_i;
        cause_d = '0;
        if (take_d) begin
            cause_d[XLEN-1] = 1'b1;
            cause_d[IW-1:0] = idx;
        end
    end

    // Output register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o  <= 1'b0;
            cause_o <= '0;
        end else begin
            take_o  <= take_d;
            cause_o <= cause_d;
        end
    end
endmodule

// File: rtl/irq_arbiter_chk.sv
// Module: irq_arbiter_chk
// Checker for irq_arbiter, attached through bind. It only observes ports.
module irq_arbiter_chk
    import irq_sel_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int IW  = $clog2(XLEN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pend_i,
    input logic [1:0]      priv_i,
    input logic            virt_i,
    input logic            dbg_i,
    input logic            mie_i,
    input logic            sie_i,
    input logic [XLEN-1:0] mdeleg_i,
    input logic [XLEN-1:0] hdeleg_i,
    input logic            take_o,
    input logic [XLEN-1:0] cause_o
);
    logic [XLEN-1:0] pend_q;

    // Copy of the pending vector from the previous edge
    always_ff @(posedge clk) pend_q <= pend_i;

    a_r6_debug_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_i |=> !take_o);

    a_r10_cause_format: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (cause_o[XLEN-1] && (cause_o[XLEN-2:IW] == '0)));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (cause_o == '0));

    a_r2_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> pend_q[cause_o[IW-1:0]]);

    a_r9_reserved_bits: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ((cause_o[IW-1:0] != IW'(0)) && (cause_o[IW-1:0] != IW'(4))
                    && (cause_o[IW-1:0] != IW'(8))));

    a_r3_m_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i == PRIV_M && !mie_i && mdeleg_i == '0) |=> !take_o);
endmodule

bind irq_arbiter irq_arbiter_chk #(.XLEN(XLEN)) i_chk (.*);

// File: tb/test_irq_arbiter.sv
// Bench for irq_arbiter: a vector table walked by one loop, then directed
// tests for reset and latency.
module test_irq_arbiter;
    localparam int XLEN = 64;

    typedef struct packed {
        logic [63:0] pend;
        logic [1:0]  priv;
        logic        virt;
        logic        dbg;
        logic        mie;
        logic        sie;
        logic [63:0] mdeleg;
        logic [63:0] hdeleg;
        logic        take;
        logic [5:0]  idx;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        // R3: machine tier enable rule
        '{64'h800, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 6'd11, 4'd3},
        '{64'h800, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 6'd0,  4'd3},
        '{64'h800, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 1'b1, 6'd11, 4'd3},
        '{64'h800, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 1'b1, 6'd11, 4'd3},
        // R4: supervisor tier
        '{64'h200, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 64'h200, 64'h0, 1'b1, 6'd9, 4'd4},
        '{64'h200, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h200, 64'h0, 1'b0, 6'd0, 4'd4},
        '{64'h200, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h200, 64'h0, 1'b1, 6'd9, 4'd4},
        '{64'h200, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h200, 64'h0, 1'b1, 6'd9, 4'd4},
        '{64'h200, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 64'h200, 64'h0, 1'b0, 6'd0, 4'd4},
        '{64'h280, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 64'h200, 64'h0, 1'b1, 6'd7, 4'd4},
        // R5: virtual-supervisor tier
        '{64'h400, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 64'h400, 64'h400, 1'b1, 6'd10, 4'd5},
        '{64'h400, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 64'h400, 64'h400, 1'b0, 6'd0,  4'd5},
        '{64'h400, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h400, 64'h400, 1'b0, 6'd0,  4'd5},
        '{64'h400, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 64'h400, 64'h400, 1'b1, 6'd10, 4'd5},
        '{64'h600, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h600, 64'h400, 1'b1, 6'd9,  4'd5},
        // R6: debug mode
        '{64'h800, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0, 64'h0, 1'b0, 6'd0, 4'd6},
        '{64'h400, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 64'h400, 64'h400, 1'b0, 6'd0, 4'd6},
        // R7: platform bits
        '{64'h0000_0100_0010_0800, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 6'd20, 4'd7},
        '{64'h8000_0000_0000_0800, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 6'd63, 4'd7},
        '{64'h1EEE, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 6'd12, 4'd7},
        // R8: standard ranking cascade
        '{64'hEEE, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 6'd11, 4'd8},
        '{64'h6EE, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 6'd3,  4'd8},
        '{64'h6E6, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 6'd7,  4'd8},
        '{64'h666, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 6'd9,  4'd8},
        '{64'h466, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 6'd1,  4'd8},
        '{64'h464, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 6'd5,  4'd8},
        '{64'h444, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 6'd10, 4'd8},
        '{64'h044, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 6'd2,  4'd8},
        '{64'h040, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 6'd6,  4'd8},
        // R9: reserved standard bits
        '{64'h001, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b0, 6'd0, 4'd9},
        '{64'h010, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b0, 6'd0, 4'd9},
        '{64'h100, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b0, 6'd0, 4'd9},
        '{64'h151, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 6'd6, 4'd9}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic [XLEN-1:0] pend_i, mdeleg_i, hdeleg_i;
    logic [1:0]      priv_i;
    logic            virt_i, dbg_i, mie_i, sie_i;
    logic            take_o;
    logic [XLEN-1:0] cause_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    irq_arbiter #(.XLEN(XLEN)) i_irq_arbiter (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend_i),
        .priv_i   (priv_i),
        .virt_i   (virt_i),
        .dbg_i    (dbg_i),
        .mie_i    (mie_i),
        .sie_i    (sie_i),
        .mdeleg_i (mdeleg_i),
        .hdeleg_i (hdeleg_i),
        .take_o   (take_o),
        .cause_o  (cause_o)
    );

    function automatic logic [XLEN-1:0] exp_cause(input logic t, input logic [5:0] idx);
        logic [XLEN-1:0] c;
        c = '0;
        if (t) begin
            c[XLEN-1] = 1'b1;
            c[5:0]    = idx;
        end
        return c;
    endfunction

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        pend_i   = v.pend;
        priv_i   = v.priv;
        virt_i   = v.virt;
        dbg_i    = v.dbg;
        mie_i    = v.mie;
        sie_i    = v.sie;
        mdeleg_i = v.mdeleg;
        hdeleg_i = v.hdeleg;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        // R1: reset state, with an interrupt pending
        check("R1 take in reset", XLEN'(take_o), '0);
        check("R1 cause in reset", cause_o, '0);
        rst_n = 1'b1;

        // Table walk (R3..R10)
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VECS[k]);
            @(negedge clk);
            check($sformatf("R%0d row %0d take", VECS[k].req, k), XLEN'(take_o), XLEN'(VECS[k].take));
            check($sformatf("R10 row %0d cause", k), cause_o, exp_cause(VECS[k].take, VECS[k].idx));
        end

        // R2: output holds until the next edge, then follows the new inputs
        @(negedge clk);
        drive(VECS[0]);
        @(negedge clk);
        check("R2 take before change", XLEN'(take_o), 1);
        pend_i = '0;
        #5;
        check("R2 take held before edge", XLEN'(take_o), 1);
        check("R2 cause held before edge", cause_o, exp_cause(1'b1, 6'd11));
        @(negedge clk);
        check("R2 take after edge", XLEN'(take_o), 0);

        // R1: reset in mid-run clears a taken interrupt
        drive(VECS[0]);
        @(negedge clk);
        check("R1 take before reset", XLEN'(take_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 take after reset", XLEN'(take_o), 0);
        check("R1 cause after reset", cause_o, '0);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule